// File: doc/BRIEF.md
# Latched Bidirectional Parity Transceiver

This block moves an 8-bit byte and its parity bit between two ports, A and B, in both directions at once. Each direction has its own capture register that acts as a clocked transparent latch: while its load input is high it takes new data and parity on every clock edge, and while the load input is low it keeps what it last took. The parity bit sent to the far port is either generated from the held byte or copied from the held incoming parity bit, chosen by one feed-through input. One sense input selects odd or even parity for both generation and checking.

Each side also checks its own incoming byte against its own incoming parity bit, in both modes and whatever the drive enables are, and reports the result on an active-low error flag. Drive enables are active low. The A side is exposed as a value plus an output-enable. The B side behaves like an open-collector bus: when it is not driven, every B output bit reads high. All outputs are registered.

Top module: `parity_xcvr`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become `a_oe`=0, `a_dout`=0, `a_par_out`=0, `b_dout`=all ones, `b_par_out`=1, `a_err_n`=1, `b_err_n`=1.
- R2: A capture register loads its side's data and parity bit at each edge where its load input (`ab_load` for A, `ba_load` for B) is high, and keeps its contents unchanged while the load input is low; a loaded value reaches the outputs at the second edge after it is presented.
- R3: With `feed_thru`=0, the parity bit driven to the far port is generated from the held byte of that direction.
- R4: With `feed_thru`=1, the parity bit driven to the far port is the held incoming parity bit of that direction, unchanged.
- R5: `odd_sense`=1 selects odd parity (generated bit makes the count of ones in byte plus parity odd); `odd_sense`=0 selects even parity. The same sense is used for checking.
- R6: `a_err_n` is 0 exactly when the held A byte and held A parity bit do not meet the selected sense, in both modes and for all drive enable values.
- R7: `b_err_n` is 0 exactly when the held B byte and held B parity bit do not meet the selected sense, in both modes and for all drive enable values.
- R8: With `ba_drive_n`=0 the A side drives (`a_oe`=1, `a_dout` = held B byte, `a_par_out` = B-to-A parity); with `ba_drive_n`=1, `a_oe`=0 and `a_dout`, `a_par_out` are 0.
- R9: With `ab_drive_n`=1 the B side is released: `b_dout` is all ones and `b_par_out` is 1; with `ab_drive_n`=0 it carries the held A byte and the A-to-B parity bit.
- R10: The two directions are independent: both may drive at the same time, and changes of `ab_drive_n`, `ba_drive_n`, `feed_thru` or `odd_sense` show at the outputs from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_din | input | W | Byte arriving on the A side |
| a_par_in | input | 1 | Parity bit arriving on the A side |
| b_din | input | W | Byte arriving on the B side |
| b_par_in | input | 1 | Parity bit arriving on the B side |
| ab_load | input | 1 | A-to-B capture open (high) or hold (low) |
| ba_load | input | 1 | B-to-A capture open (high) or hold (low) |
| ab_drive_n | input | 1 | Active-low drive enable of the B side |
| ba_drive_n | input | 1 | Active-low drive enable of the A side |
| feed_thru | input | 1 | 1: copy incoming parity, 0: generate parity |
| odd_sense | input | 1 | 1: odd parity, 0: even parity |
| a_dout | output | W | Byte driven on the A side |
| a_par_out | output | 1 | Parity bit driven on the A side |
| a_oe | output | 1 | A side output enable |
| b_dout | output | W | B side bus value, all ones when released |
| b_par_out | output | 1 | B side parity bus value, 1 when released |
| a_err_n | output | 1 | Low when A byte and A parity disagree |
| b_err_n | output | 1 | Low when B byte and B parity disagree |

## Verification
A capture register that loads while closed, or fails to load while open, shows as a stale or premature byte on the far port and as an error flag computed from the wrong byte, two edges after the input change. A wrong parity source or sense flips the far parity bit one edge after the control changes, and the error flags expose a checker that uses the wrong sense even while a side is released. The bench therefore walks every combination of mode, sense and both drive enables over several byte patterns, and then closes both captures and changes the inputs and the sense to separate held state from live inputs.

// File: rtl/xpl_pkg.sv
`timescale 1ns/1ps
package xpl_pkg;
  typedef enum logic {SRC_GEN = 1'b0, SRC_FEED = 1'b1} par_src_e;
  typedef enum logic {SENSE_EVEN = 1'b0, SENSE_ODD = 1'b1} sense_e;
endpackage

// File: rtl/xpl_parity.sv
`timescale 1ns/1ps
module xpl_parity
  import xpl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  input  logic         p,
  input  sense_e       sense,
  output logic         gen,
  output logic         ok
);
  logic odd_sel;
  logic d_xor;

  assign odd_sel = (sense == SENSE_ODD);
  assign d_xor   = ^d;
  // generated bit completes the requested count of ones
  assign gen = d_xor ^ odd_sel;
  // byte plus parity has a count of ones matching the sense
  assign ok  = ((d_xor ^ p) == odd_sel);
endmodule

// File: rtl/xpl_lane.sv
`timescale 1ns/1ps
module xpl_lane
  import xpl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic [W-1:0] din,
  input  logic         pin,
  input  par_src_e     src,
  input  sense_e       sense,
  output logic [W-1:0] held_d,
  output logic         held_p,
  output logic         fwd_p,
  output logic         chk_ok
);
  logic gen_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_d <= '0;
      held_p <= 1'b0;
    end else if (cap_en) begin
      held_d <= din;
      held_p <= pin;
    end
  end

  xpl_parity #(.W(W)) u_par (
    .d     (held_d),
    .p     (held_p),
    .sense (sense),
    .gen   (gen_p),
    .ok    (chk_ok)
  );

  assign fwd_p = (src == SRC_FEED) ? held_p : gen_p;
endmodule

// File: rtl/parity_xcvr.sv
`timescale 1ns/1ps
module parity_xcvr
  import xpl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_din,
  input  logic         a_par_in,
  input  logic [W-1:0] b_din,
  input  logic         b_par_in,
  input  logic         ab_load,
  input  logic         ba_load,
  input  logic         ab_drive_n,
  input  logic         ba_drive_n,
  input  logic         feed_thru,
  input  logic         odd_sense,
  output logic [W-1:0] a_dout,
  output logic         a_par_out,
  output logic         a_oe,
  output logic [W-1:0] b_dout,
  output logic         b_par_out,
  output logic         a_err_n,
  output logic         b_err_n
);
  par_src_e     src;
  sense_e       sense;
  logic [W-1:0] ab_held_d, ba_held_d;
  logic         ab_held_p, ba_held_p;
  logic         ab_fwd_p, ba_fwd_p;
  logic         ab_ok, ba_ok;
  logic [W-1:0] b_nxt, a_nxt;

  assign src   = feed_thru ? SRC_FEED : SRC_GEN;
  assign sense = odd_sense ? SENSE_ODD : SENSE_EVEN;

  xpl_lane #(.W(W)) u_ab (
    .clk    (clk),
    .rst    (rst),
    .cap_en (ab_load),
    .din    (a_din),
    .pin    (a_par_in),
    .src    (src),
    .sense  (sense),
    .held_d (ab_held_d),
    .held_p (ab_held_p),
    .fwd_p  (ab_fwd_p),
    .chk_ok (ab_ok)
  );

  xpl_lane #(.W(W)) u_ba (
    .clk    (clk),
    .rst    (rst),
    .cap_en (ba_load),
    .din    (b_din),
    .pin    (b_par_in),
    .src    (src),
    .sense  (sense),
    .held_d (ba_held_d),
    .held_p (ba_held_p),
    .fwd_p  (ba_fwd_p),
    .chk_ok (ba_ok)
  );

  // per-bit drivers: B side releases to high, A side parks at zero
  for (genvar i = 0; i < W; i++) begin : g_drv
    assign b_nxt[i] = ab_drive_n ? 1'b1 : ab_held_d[i];
    assign a_nxt[i] = ba_drive_n ? 1'b0 : ba_held_d[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_dout    <= '1;
      b_par_out <= 1'b1;
      a_dout    <= '0;
      a_par_out <= 1'b0;
      a_oe      <= 1'b0;
      a_err_n   <= 1'b1;
      b_err_n   <= 1'b1;
    end else begin
      b_dout    <= b_nxt;
      b_par_out <= ab_drive_n ? 1'b1 : ab_fwd_p;
      a_dout    <= a_nxt;
      a_par_out <= ba_drive_n ? 1'b0 : ba_fwd_p;
      a_oe      <= ~ba_drive_n;
      a_err_n   <= ab_ok;
      b_err_n   <= ba_ok;
    end
  end
endmodule

// File: rtl/parity_xcvr_chk.sv
`timescale 1ns/1ps
module parity_xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         ab_load,
  input logic         ab_drive_n,
  input logic         ba_drive_n,
  input logic         feed_thru,
  input logic         odd_sense,
  input logic [W-1:0] ab_held_d,
  input logic         ab_held_p,
  input logic [W-1:0] ba_held_d,
  input logic         ba_held_p,
  input logic [W-1:0] b_dout,
  input logic         b_par_out,
  input logic         a_oe,
  input logic         a_err_n,
  input logic         b_err_n
);
  AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (rst)
    !ab_load |=> ($stable(ab_held_d) && $stable(ab_held_p))); // R2
  AST_GEN_SENSE: assert property (@(posedge clk) disable iff (rst)
    (!ab_drive_n && !feed_thru) |=> ((^{b_dout, b_par_out}) == $past(odd_sense))); // R3
  AST_FEED_COPY: assert property (@(posedge clk) disable iff (rst)
    (!ab_drive_n && feed_thru) |=> (b_par_out == $past(ab_held_p))); // R4
  AST_A_ERR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (a_err_n == ((^{$past(ab_held_d), $past(ab_held_p)}) == $past(odd_sense)))); // R6
  AST_B_ERR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (b_err_n == ((^{$past(ba_held_d), $past(ba_held_p)}) == $past(odd_sense)))); // R7
  AST_A_ENABLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (a_oe == !$past(ba_drive_n))); // R8
  AST_B_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ab_drive_n |=> ((&b_dout) && b_par_out)); // R9
endmodule

bind parity_xcvr parity_xcvr_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ab_load    (ab_load),
  .ab_drive_n (ab_drive_n),
  .ba_drive_n (ba_drive_n),
  .feed_thru  (feed_thru),
  .odd_sense  (odd_sense),
  .ab_held_d  (ab_held_d),
  .ab_held_p  (ab_held_p),
  .ba_held_d  (ba_held_d),
  .ba_held_p  (ba_held_p),
  .b_dout     (b_dout),
  .b_par_out  (b_par_out),
  .a_oe       (a_oe),
  .a_err_n    (a_err_n),
  .b_err_n    (b_err_n)
);

// File: tb/parity_xcvr_test.sv
`timescale 1ns/1ps
module parity_xcvr_test;
  localparam int W = 8;
  localparam int NV = 6;
  // {a byte, a parity, b byte, b parity}
  localparam logic [17:0] VEC [NV] = '{
    {8'h00, 1'b0, 8'hFF, 1'b1},
    {8'hA5, 1'b1, 8'h01, 1'b0},
    {8'h01, 1'b0, 8'h80, 1'b1},
    {8'hFF, 1'b0, 8'h3C, 1'b0},
    {8'h7E, 1'b1, 8'hC3, 1'b1},
    {8'h96, 1'b0, 8'h17, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_din = '0, b_din = '0;
  logic         a_par_in = 1'b0, b_par_in = 1'b0;
  logic         ab_load = 1'b1, ba_load = 1'b1;
  logic         ab_drive_n = 1'b1, ba_drive_n = 1'b1;
  logic         feed_thru = 1'b0, odd_sense = 1'b0;
  logic [W-1:0] a_dout, b_dout;
  logic         a_par_out, a_oe, b_par_out, a_err_n, b_err_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  parity_xcvr #(.W(W)) uut (
    .clk(clk), .rst(rst),
    .a_din(a_din), .a_par_in(a_par_in), .b_din(b_din), .b_par_in(b_par_in),
    .ab_load(ab_load), .ba_load(ba_load),
    .ab_drive_n(ab_drive_n), .ba_drive_n(ba_drive_n),
    .feed_thru(feed_thru), .odd_sense(odd_sense),
    .a_dout(a_dout), .a_par_out(a_par_out), .a_oe(a_oe),
    .b_dout(b_dout), .b_par_out(b_par_out),
    .a_err_n(a_err_n), .b_err_n(b_err_n)
  );

  function automatic logic gen_par(input logic [W-1:0] d, input logic odd);
    int ones = 0;
    for (int i = 0; i < W; i++) ones += int'(d[i]);
    // parity bit that makes total ones odd (odd=1) or even (odd=0)
    return ((ones % 2) == 1) ? !odd : odd;
  endfunction

  function automatic logic chk_ok(input logic [W-1:0] d, input logic p, input logic odd);
    int ones = int'(p);
    for (int i = 0; i < W; i++) ones += int'(d[i]);
    return ((ones % 2) == 1) == odd;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  // expected output model for a held state and the current controls
  task automatic expect_all(input string tag, input logic [W-1:0] ad, input logic ap,
                            input logic [W-1:0] bd, input logic bp);
    logic exp_bp, exp_ap;
    exp_bp = ab_drive_n ? 1'b1 : (feed_thru ? ap : gen_par(ad, odd_sense));
    exp_ap = ba_drive_n ? 1'b0 : (feed_thru ? bp : gen_par(bd, odd_sense));
    check({tag, " R9 R10 b_dout"}, 16'(b_dout), 16'(ab_drive_n ? 8'hFF : ad));
    check({tag, " R3 R4 R5 R9 b_par_out"}, 16'(b_par_out), 16'(exp_bp));
    check({tag, " R8 a_oe"}, 16'(a_oe), 16'(!ba_drive_n));
    check({tag, " R8 R10 a_dout"}, 16'(a_dout), 16'(ba_drive_n ? 8'h00 : bd));
    check({tag, " R3 R4 R5 R8 a_par_out"}, 16'(a_par_out), 16'(exp_ap));
    check({tag, " R6 a_err_n"}, 16'(a_err_n), 16'(chk_ok(ad, ap, odd_sense)));
    check({tag, " R7 b_err_n"}, 16'(b_err_n), 16'(chk_ok(bd, bp, odd_sense)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 a_oe", 16'(a_oe), 16'h0);
    check("R1 a_dout", 16'(a_dout), 16'h0);
    check("R1 a_par_out", 16'(a_par_out), 16'h0);
    check("R1 b_dout", 16'(b_dout), 16'h00FF);
    check("R1 b_par_out", 16'(b_par_out), 16'h1);
    check("R1 a_err_n", 16'(a_err_n), 16'h1);
    check("R1 b_err_n", 16'(b_err_n), 16'h1);
    rst = 1'b0;

    // table walk: every mode, sense and enable pair for each pattern
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < 16; c++) begin
        {a_din, a_par_in, b_din, b_par_in} = VEC[v];
        feed_thru  = c[0];
        odd_sense  = c[1];
        ab_drive_n = c[2];
        ba_drive_n = c[3];
        settle();
        expect_all("table R2", VEC[v][17:10], VEC[v][9], VEC[v][8:1], VEC[v][0]);
      end
    end

    // R2: capture closed holds old data while inputs change
    ab_drive_n = 1'b0; ba_drive_n = 1'b0; feed_thru = 1'b0; odd_sense = 1'b1;
    a_din = 8'h3A; a_par_in = 1'b1; b_din = 8'h5C; b_par_in = 1'b0;
    settle();
    expect_all("load R2", 8'h3A, 1'b1, 8'h5C, 1'b0);
    ab_load = 1'b0; ba_load = 1'b0;
    a_din = 8'hC1; a_par_in = 1'b0; b_din = 8'h0F; b_par_in = 1'b1;
    settle();
    expect_all("closed R2", 8'h3A, 1'b1, 8'h5C, 1'b0);
    // R5 R6: sense change while closed re-evaluates held data
    odd_sense = 1'b0;
    settle();
    expect_all("closed sense R5 R6 R7", 8'h3A, 1'b1, 8'h5C, 1'b0);
    // R4: feed-through of held parity while closed
    feed_thru = 1'b1;
    settle();
    expect_all("closed feed R4", 8'h3A, 1'b1, 8'h5C, 1'b0);
    // R2: reopen one direction only
    ab_load = 1'b1;
    settle();
    expect_all("reopen ab R2", 8'hC1, 1'b0, 8'h5C, 1'b0);
    ba_load = 1'b1;
    settle();
    expect_all("reopen ba R2", 8'hC1, 1'b0, 8'h0F, 1'b1);

    // R10: control change visible one edge later
    @(negedge clk);
    ab_drive_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 release latency b_dout", 16'(b_dout), 16'h00FF);
    check("R10 release latency b_par_out", 16'(b_par_out), 16'h1);

    // R1: reset mid-run restores reset state
    ab_drive_n = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 rerun b_dout", 16'(b_dout), 16'h00FF);
    check("R1 rerun a_oe", 16'(a_oe), 16'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule